// File: doc/BRIEF.md
# Dual-Mode 8-bit PWM / Interval Timer

The block is an up-counter peripheral with two byte-wide registers on a simple register bus: a control register at address 0 and a compare register at address 1. In interval mode the counter climbs to the compare value. On the count tick where the two are equal it wraps to zero, toggles a square-wave output and sets a match flag. That flag can drive an interrupt, and software clears it by writing zero to it. In PWM mode the counter runs freely through its whole range. The output stays high while the count is below the compare value, so the compare register sets the duty cycle. This mode never raises the flag.

The counter advances only on a count tick. Software picks the tick from one of three internal clock enables, which come from a prescaler outside the block, or from the rising edge of a pulse that an external timer delivers. An output-select bit routes either this timer's waveform or a general-purpose port bit to the pin. Mode and clock source can be changed only while the counter is stopped.

Top module: `pwm_interval_timer`

## Requirements
- R1: Control register layout: bit 7 mode (0 interval, 1 PWM), bits 5:4 clock source, bit 3 run, bit 2 match flag, bit 1 pin select, bit 0 interrupt enable. A write with bus_addr 0 reaches control and a write with bus_addr 1 reaches compare. bus_rdata returns the register that bus_addr selects. After reset both registers read 0x00.
- R2: Clock source codes: 00 counts on ce_int[0], 01 on ce_int[1], 10 on ce_int[2], 11 on each rising edge of ext_pulse. No other input advances the counter.
- R3: While run is 0 the count is held at 0x00 and the timer waveform is low. Writing run=0 and then run=1 restarts counting from 0x00.
- R4: In interval mode with compare value N, the tick that finds the count equal to N sets the flag, returns the count to 0x00 and toggles the square wave. The wave therefore changes level every N+1 ticks and starts low.
- R5: A control write with bit 2 at 0 clears the flag. A write with bit 2 at 1 leaves the flag unchanged. If a match and a clearing write arrive in the same cycle, the flag ends up set.
- R6: irq is high exactly when the flag and the interrupt-enable bit are both 1.
- R7: With pin select 0, pin_out follows gpio_bit. With pin select 1, pin_out carries the timer waveform.
- R8: Bit 6 of the control register ignores writes and always reads 0.
- R9: In PWM mode the count wraps from 0xFF to 0x00, and the waveform is high exactly while the count is below the compare value. A compare value of 0x00 holds the waveform low.
- R10: In PWM mode a compare match never sets the flag and never raises irq.
- R11: While run is 1, control writes leave the mode bit and the clock-source bits unchanged. Run, pin select, interrupt enable and the flag-clear action still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 compare |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| ce_int | input | 3 | Internal count-clock enables from the prescaler |
| ext_pulse | input | 1 | Output pulse of an external timer, used as a count source |
| gpio_bit | input | 1 | General-purpose port value for the shared pin |
| pin_out | output | 1 | Shared pin: port bit or timer waveform |
| irq | output | 1 | Interrupt request |

## Verification
The count cannot be read directly, so a wrong count shows up at the ports through the flag, irq and pin_out. A count that starts wrong or steps wrong moves the first flag set or wave toggle by at least one tick in interval mode. In PWM mode it moves the high-to-low edge of pin_out within one period. An error in the clock selection shows up in the first few pulses on an input that should not advance the counter. A flag or mode bit that changes when it should not appears on bus_rdata on the very next read.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   localparam int REG_W  = 8;
   localparam int B_MODE = 7;
   localparam int B_RSV  = 6;
   localparam int B_SRCH = 5;
   localparam int B_SRCL = 4;
   localparam int B_RUN  = 3;
   localparam int B_FLAG = 2;
   localparam int B_PSEL = 1;
   localparam int B_IEN  = 0;

   typedef enum logic [1:0] {
      SRC_CE0 = 2'b00,
      SRC_CE1 = 2'b01,
      SRC_CE2 = 2'b10,
      SRC_EXT = 2'b11
   } clk_src_e;

   typedef struct packed {
      logic     pwm_mode;
      clk_src_e src;
      logic     run;
      logic     flag;
      logic     pin_sel;
      logic     irq_en;
   } ctl_t;
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
   import pwmt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               addr,
   input  logic [REG_W-1:0]   wdata,
   input  logic               match_set,
   output ctl_t               ctl,
   output logic [CNT_W-1:0]   cmp,
   output logic [REG_W-1:0]   rdata
);
   logic wr_ctl, wr_cmp;
   logic unused_rsv;

   assign wr_ctl     = wr && (addr == 1'b0);
   assign wr_cmp     = wr && (addr == 1'b1);
   assign unused_rsv = wdata[B_RSV];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         if (wr_ctl) begin
            if (!ctl.run) begin
               ctl.pwm_mode <= wdata[B_MODE];
               ctl.src      <= clk_src_e'(wdata[B_SRCH:B_SRCL]);
            end
            ctl.run     <= wdata[B_RUN];
            ctl.pin_sel <= wdata[B_PSEL];
            ctl.irq_en  <= wdata[B_IEN];
         end
         if (match_set)
            ctl.flag <= 1'b1;
         else if (wr_ctl && !wdata[B_FLAG])
            ctl.flag <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cmp <= '0;
      else if (wr_cmp) cmp <= wdata[CNT_W-1:0];
   end

   always_comb begin
      rdata = '0;
      if (addr == 1'b0) begin
         rdata[B_MODE]          = ctl.pwm_mode;
         rdata[B_SRCH:B_SRCL]   = ctl.src;
         rdata[B_RUN]           = ctl.run;
         rdata[B_FLAG]          = ctl.flag;
         rdata[B_PSEL]          = ctl.pin_sel;
         rdata[B_IEN]           = ctl.irq_en;
      end else begin
         rdata[CNT_W-1:0]       = cmp;
      end
   end

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && ctl.run) |=> ($stable(ctl.pwm_mode) && $stable(ctl.src))); // R11
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !wdata[B_FLAG] && !match_set) |=> !ctl.flag); // R5
   AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.flag) |-> $past(match_set)); // R4
endmodule

// File: rtl/pwmt_tick_sel.sv
module pwmt_tick_sel
   import pwmt_pkg::*;
#(
   parameter int N_CE     = 3,
   parameter bit EXT_EDGE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CE-1:0] ce_int,
   input  logic            ext_in,
   input  clk_src_e        src,
   output logic            tick
);
   logic ext_tick;

   generate
      if (EXT_EDGE) begin : g_edge
         logic ext_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ext_q <= 1'b0;
            else        ext_q <= ext_in;
         end
         assign ext_tick = ext_in && !ext_q;
      end else begin : g_level
         assign ext_tick = ext_in;
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_CE0: tick = ce_int[0];
         SRC_CE1: tick = ce_int[1];
         SRC_CE2: tick = ce_int[2];
         SRC_EXT: tick = ext_tick;
         default: tick = 1'b0;
      endcase
   end

   AST_TICK_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && src != SRC_EXT) |-> ce_int[src]); // R2
endmodule

// File: rtl/pwmt_core.sv
module pwmt_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             pwm_mode,
   input  logic [CNT_W-1:0] cmp,
   output logic             wave,
   output logic             match_set
);
   logic [CNT_W-1:0] cnt;
   logic             sq;
   logic             hit;

   assign hit       = (cnt == cmp);
   assign match_set = tick && run && !pwm_mode && hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         sq  <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         sq  <= 1'b0;
      end else if (tick) begin
         if (pwm_mode) begin
            cnt <= cnt + 1'b1;
         end else if (hit) begin
            cnt <= '0;
            sq  <= !sq;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_comb begin
      if (!run)          wave = 1'b0;
      else if (pwm_mode) wave = (cnt < cmp);
      else               wave = sq;
   end

   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0 && !sq)); // R3
   AST_INT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !pwm_mode && hit) |=> (cnt == '0 && sq != $past(sq))); // R4
   AST_PWM_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && pwm_mode && cnt == '1) |=> cnt == '0); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick && $past(run)) |=> $stable(cnt) || !run); // R2
endmodule

// File: rtl/pwm_interval_timer.sv
module pwm_interval_timer
   import pwmt_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit EXT_EDGE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic [2:0] ce_int,
   input  logic       ext_pulse,
   input  logic       gpio_bit,
   output logic       pin_out,
   output logic       irq
);
   localparam int N_CE = 3;

   generate
      if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_width
         $error("pwm_interval_timer: CNT_W must lie in 2..8");
      end
   endgenerate

   ctl_t             ctl;
   logic [CNT_W-1:0] cmp;
   logic             tick, wave, match_set;

   pwmt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .match_set(match_set), .ctl(ctl),
      .cmp(cmp), .rdata(bus_rdata)
   );

   pwmt_tick_sel #(.N_CE(N_CE), .EXT_EDGE(EXT_EDGE)) u_tick (
      .clk(clk), .rst_n(rst_n), .ce_int(ce_int), .ext_in(ext_pulse),
      .src(ctl.src), .tick(tick)
   );

   pwmt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctl.run),
      .pwm_mode(ctl.pwm_mode), .cmp(cmp), .wave(wave),
      .match_set(match_set)
   );

   assign pin_out = ctl.pin_sel ? wave : gpio_bit;
   assign irq     = ctl.flag && ctl.irq_en;

   AST_PWM_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.pwm_mode && !irq && !(bus_wr && !bus_addr && !ctl.run)) |=> !irq); // R10
   AST_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.pin_sel && !ctl.run) |-> !pin_out); // R3
endmodule

// File: tb/tb_pwm_interval_timer.sv
`timescale 1ns/1ps
module tb_pwm_interval_timer;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_wr;
   logic       bus_addr;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic [2:0] ce_int;
   logic       ext_pulse;
   logic       gpio_bit;
   logic       pin_out;
   logic       irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = !clk;

   pwm_interval_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ce_int(ce_int),
      .ext_pulse(ext_pulse), .gpio_bit(gpio_bit), .pin_out(pin_out), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   // src 0..2 pulses ce_int[src]; 3 pulses ext_pulse
   task automatic pulse(input int src, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (src == 3) ext_pulse = 1'b1; else ce_int[src] = 1'b1;
         @(negedge clk);
         ext_pulse = 1'b0; ce_int = '0;
      end
   endtask

   task automatic flag_now(output logic f);
      logic [7:0] d;
      rd(1'b0, d);
      f = d[2];
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(1'b0, d); chk("R1 ctrl reset", d, 8'h00);
      rd(1'b1, d); chk("R1 cmp reset", d, 8'h00);
      chk("R6 irq reset", {7'd0, irq}, 8'h00);
      gpio_bit = 1'b1; #0.5;
      chk("R7 pin follows gpio 1", {7'd0, pin_out}, 8'h01);
      gpio_bit = 1'b0; #0.5;
      chk("R7 pin follows gpio 0", {7'd0, pin_out}, 8'h00);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(1'b1, 8'hA5);
      rd(1'b1, d); chk("R1 cmp readback", d, 8'hA5);
      wr(1'b0, 8'h43); // bit6 set, pin sel, irq en, stopped
      rd(1'b0, d); chk("R8 bit6 reads 0", d, 8'h03);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_interval();
      logic f; logic [7:0] d;
      wr(1'b1, 8'h03);
      wr(1'b0, 8'h0B); // interval, src 00, run, pin sel, irq en
      chk("R4 wave starts low", {7'd0, pin_out}, 8'h00);
      pulse(0, 3);
      flag_now(f); chk("R4 no flag before match", {7'd0, f}, 8'h00);
      chk("R4 wave low before match", {7'd0, pin_out}, 8'h00);
      pulse(0, 1);
      flag_now(f); chk("R4 flag at match", {7'd0, f}, 8'h01);
      chk("R4 wave toggles high", {7'd0, pin_out}, 8'h01);
      chk("R6 irq with flag and enable", {7'd0, irq}, 8'h01);
      wr(1'b0, 8'h0E); // ien off, keep flag (bit2=1)
      chk("R6 irq masked", {7'd0, irq}, 8'h00);
      flag_now(f); chk("R5 write 1 keeps flag", {7'd0, f}, 8'h01);
      wr(1'b0, 8'h0B); // bit2=0 clears
      flag_now(f); chk("R5 write 0 clears flag", {7'd0, f}, 8'h00);
      chk("R6 irq low after clear", {7'd0, irq}, 8'h00);
      pulse(0, 3);
      chk("R4 wave still high", {7'd0, pin_out}, 8'h01);
      pulse(0, 1);
      chk("R4 wave toggles low after N+1", {7'd0, pin_out}, 8'h00);
      pulse(0, 4);
      chk("R4 wave high again", {7'd0, pin_out}, 8'h01);
      wr(1'b0, 8'h02); // stop
      chk("R3 pin low when stopped", {7'd0, pin_out}, 8'h00);
      rd(1'b0, d); chk("R3 stopped ctrl", d, 8'h02);
   endtask

   task automatic t_restart();
      logic f;
      wr(1'b1, 8'h03);
      wr(1'b0, 8'h0A);
      pulse(0, 2);
      wr(1'b0, 8'h02);
      pulse(0, 2);
      wr(1'b0, 8'h0A);
      pulse(0, 3);
      flag_now(f); chk("R3 count restarted from 0", {7'd0, f}, 8'h00);
      pulse(0, 1);
      flag_now(f); chk("R3 match after full restart", {7'd0, f}, 8'h01);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_sources();
      logic f;
      wr(1'b1, 8'h02);
      for (int s = 1; s < 4; s++) begin
         wr(1'b0, 8'h08 | 8'(s << 4));
         pulse(0, 5);
         if (s != 1) pulse(1, 5);
         if (s != 2) pulse(2, 5);
         if (s != 3) pulse(3, 5);
         flag_now(f); chk($sformatf("R2 src %0d ignores others", s), {7'd0, f}, 8'h00);
         pulse(s, 3);
         flag_now(f); chk($sformatf("R2 src %0d counts", s), {7'd0, f}, 8'h01);
         wr(1'b0, 8'h00);
      end
      // a held external level gives only one tick
      wr(1'b0, 8'h38);
      @(negedge clk); ext_pulse = 1'b1;
      repeat (6) @(negedge clk);
      ext_pulse = 1'b0;
      pulse(3, 1);
      flag_now(f); chk("R2 ext counts edges only", {7'd0, f}, 8'h00);
      pulse(3, 1);
      flag_now(f); chk("R2 ext third edge matches", {7'd0, f}, 8'h01);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_frozen();
      logic [7:0] d; logic f;
      wr(1'b1, 8'h01);
      wr(1'b0, 8'h08);
      wr(1'b0, 8'h98); // try pwm mode and src 01 while running
      rd(1'b0, d); chk("R11 mode/src held", d, 8'h08);
      pulse(0, 2);
      flag_now(f); chk("R11 still counts on ce0", {7'd0, f}, 8'h01);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_pwm();
      logic f;
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h02);
      wr(1'b0, 8'h8B); // pwm, src 00, run, pin, ien
      chk("R9 high at count 0", {7'd0, pin_out}, 8'h01);
      pulse(0, 1);
      chk("R9 high at count 1", {7'd0, pin_out}, 8'h01);
      pulse(0, 1);
      chk("R9 low at count == cmp", {7'd0, pin_out}, 8'h00);
      pulse(0, 253);
      chk("R9 low at count FF", {7'd0, pin_out}, 8'h00);
      flag_now(f); chk("R10 no flag in pwm", {7'd0, f}, 8'h00);
      chk("R10 no irq in pwm", {7'd0, irq}, 8'h00);
      pulse(0, 1);
      chk("R9 wrap to 0 high", {7'd0, pin_out}, 8'h01);
      wr(1'b1, 8'h00);
      chk("R9 cmp 0 low", {7'd0, pin_out}, 8'h00);
      pulse(0, 7);
      chk("R9 cmp 0 stays low", {7'd0, pin_out}, 8'h00);
      wr(1'b1, 8'hFF);
      chk("R9 cmp FF high", {7'd0, pin_out}, 8'h01);
      wr(1'b0, 8'h89); // pin select off
      gpio_bit = 1'b0; #0.5;
      chk("R7 gpio routed in pwm", {7'd0, pin_out}, 8'h00);
      wr(1'b0, 8'h00);
   endtask

   initial begin
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
      ce_int = '0; ext_pulse = 1'b0; gpio_bit = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_interval();
      t_restart();
      t_sources();
      t_frozen();
      t_pwm();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule